// File: doc/BRIEF.md
# Upgrade Miss Admission Gate

This block sits between a cache request pipeline and its miss queue. It decides whether a request that needs a shared-to-exclusive permission upgrade may take a miss entry. It also decides which requester is told to replay when the upgrade is refused.

For every request it counts the miss-queue entries that are valid, target the same set and are themselves upgrades. An upgrade is admitted only while that count stays below the associativity minus one. Requests issued by the miss queue itself bypass the cap. When an upgrade is refused, a replay goes back only if the request came from the store buffer. A store-buffer hit response is never raised in the same cycle as a replay.

All decisions are registered and appear as single-cycle strobes one cycle after the request is presented.

Top module: `upg_admit_gate`

## Requirements
- R1: While rst_ni is low and on the first cycle after its release, accept_o, refuse_o, replay_o and hit_o are all 0.
- R2: The per-set upgrade count is the number of miss-queue entries with mq_valid_i, mq_upg_i and an mq_set_i slice equal to req_set_i all set. An upgrade request from a checked source is accepted when this count is below NUM_WAYS-1, which is 3 for 4 ways.
- R3: An upgrade request from a checked source is refused, with accept_o low, when the count is NUM_WAYS-1 or more.
- R4: Source codes on req_src_i are 0 for a load-pipe prefetch-for-write, 1 for the store buffer, 2 for the miss queue and 3 for another pipe. Codes 0, 1 and 3 are all subject to the cap.
- R5: An upgrade request with source code 2 is always accepted and never refused, whatever the count.
- R6: replay_o is 1 only for a refused upgrade whose source code is 1.
- R7: hit_o is 1 only for a store-buffer request (code 1) that needs no upgrade. replay_o and hit_o are never 1 together.
- R8: Each output reflects the request presented on the previous rising edge. All outputs are 0 in the cycle after an edge where req_valid_i was 0.
- R9: A valid request without req_upg_i drives accept_o and refuse_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_upg_i | input | 1 | Request needs a shared-to-exclusive upgrade |
| req_src_i | input | 2 | Request source code |
| req_set_i | input | SET_W | Set index of the request |
| mq_valid_i | input | MQ_ENTRIES | Miss-queue entry valid flags |
| mq_upg_i | input | MQ_ENTRIES | Miss-queue entry is an upgrade |
| mq_set_i | input | MQ_ENTRIES*SET_W | Packed set index per entry, entry 0 lowest |
| accept_o | output | 1 | Upgrade admitted strobe |
| refuse_o | output | 1 | Upgrade refused strobe |
| replay_o | output | 1 | Replay strobe to the store buffer |
| hit_o | output | 1 | Hit response strobe to the store buffer |

## Verification
On every cycle the assertions check the properties that hold between outputs. Accept and refuse never coincide. A replay always comes with a refusal, and replay never coincides with a hit. A refusal or a replay always traces back to a previous request from a capped source that needed an upgrade. Only the bench's sweeps can show that the count is formed correctly. It must ignore invalid entries, entries for other sets and entries that are not upgrades, and the admission threshold must sit exactly at NUM_WAYS-1. The sweeps fill a set with 0 to 4 pending upgrades around such distractor entries and issue every source code, with and without an upgrade.

// File: rtl/upg_admit_pkg.sv
package upg_admit_pkg;
  typedef enum logic [1:0] {
    SRC_LOAD  = 2'd0,
    SRC_STORE = 2'd1,
    SRC_MISSQ = 2'd2,
    SRC_OTHER = 2'd3
  } req_src_e;

  typedef struct packed {
    logic accept;
    logic refuse;
    logic replay;
    logic hit;
  } admit_res_t;
endpackage

// File: rtl/upg_set_counter.sv
module upg_set_counter #(
  parameter int MQ_ENTRIES = 8,
  parameter int SET_W      = 6,
  localparam int CNT_W     = $clog2(MQ_ENTRIES + 1)
) (
  input  logic [SET_W-1:0]            set_i,
  input  logic [MQ_ENTRIES-1:0]       mq_valid_i,
  input  logic [MQ_ENTRIES-1:0]       mq_upg_i,
  input  logic [MQ_ENTRIES*SET_W-1:0] mq_set_i,
  output logic [CNT_W-1:0]            count_o
);
  logic [MQ_ENTRIES-1:0] match;

  for (genvar e = 0; e < MQ_ENTRIES; e++) begin : g_match
    assign match[e] = mq_valid_i[e] && mq_upg_i[e] &&
                      (mq_set_i[e*SET_W +: SET_W] == set_i);
  end

  always_comb begin
    count_o = '0;
    for (int e = 0; e < MQ_ENTRIES; e++) count_o = count_o + CNT_W'(match[e]);
  end

  // R2
  always_comb count_range_chk: assert (int'(count_o) <= MQ_ENTRIES);
endmodule

// File: rtl/upg_admit_decide.sv
module upg_admit_decide
  import upg_admit_pkg::*;
#(
  parameter int NUM_WAYS   = 4,
  parameter int MQ_ENTRIES = 8,
  localparam int CNT_W     = $clog2(MQ_ENTRIES + 1),
  localparam int CAP       = NUM_WAYS - 1
) (
  input  logic             valid_i,
  input  logic             upg_i,
  input  logic [1:0]       src_i,
  input  logic [CNT_W-1:0] count_i,
  output admit_res_t       res_o
);
  logic checked, over_cap, is_store;

  assign checked  = (req_src_e'(src_i) != SRC_MISSQ);
  assign is_store = (req_src_e'(src_i) == SRC_STORE);
  assign over_cap = (int'(count_i) >= CAP);

  always_comb begin
    res_o        = '0;
    res_o.refuse = valid_i && upg_i && checked && over_cap;
    res_o.accept = valid_i && upg_i && !(checked && over_cap);
    // replay only back to the store buffer
    res_o.replay = res_o.refuse && is_store;
    res_o.hit    = valid_i && !upg_i && is_store;
  end

  // R7
  always_comb replay_hit_excl_chk: assert (!(res_o.replay && res_o.hit));
endmodule

// File: rtl/upg_admit_gate.sv
module upg_admit_gate
  import upg_admit_pkg::*;
#(
  parameter int NUM_WAYS   = 4,
  parameter int MQ_ENTRIES = 8,
  parameter int SET_W      = 6
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  input  logic                        req_upg_i,
  input  logic [1:0]                  req_src_i,
  input  logic [SET_W-1:0]            req_set_i,
  input  logic [MQ_ENTRIES-1:0]       mq_valid_i,
  input  logic [MQ_ENTRIES-1:0]       mq_upg_i,
  input  logic [MQ_ENTRIES*SET_W-1:0] mq_set_i,
  output logic                        accept_o,
  output logic                        refuse_o,
  output logic                        replay_o,
  output logic                        hit_o
);
  localparam int CNT_W = $clog2(MQ_ENTRIES + 1);

  logic [CNT_W-1:0] set_count;
  admit_res_t       res_d, res_q;

  upg_set_counter #(.MQ_ENTRIES(MQ_ENTRIES), .SET_W(SET_W)) u_cnt (
    .set_i     (req_set_i),
    .mq_valid_i(mq_valid_i),
    .mq_upg_i  (mq_upg_i),
    .mq_set_i  (mq_set_i),
    .count_o   (set_count)
  );

  upg_admit_decide #(.NUM_WAYS(NUM_WAYS), .MQ_ENTRIES(MQ_ENTRIES)) u_dec (
    .valid_i(req_valid_i),
    .upg_i  (req_upg_i),
    .src_i  (req_src_i),
    .count_i(set_count),
    .res_o  (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) res_q <= '0;
    else         res_q <= res_d;
  end

  assign accept_o = res_q.accept;
  assign refuse_o = res_q.refuse;
  assign replay_o = res_q.replay;
  assign hit_o    = res_q.hit;

  // R3
  accept_refuse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(accept_o && refuse_o));
  // R6
  replay_needs_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_o |-> refuse_o);
  // R7
  replay_hit_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(replay_o && hit_o));
  // R5
  missq_never_refused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_src_i == 2'd2) |=> !refuse_o);
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !(accept_o || refuse_o || replay_o || hit_o));
  // R9
  no_upg_no_decision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_upg_i) |=> !(accept_o || refuse_o));
endmodule

// File: tb/upg_admit_gate_test.sv
module upg_admit_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 4;
  localparam int ENT  = 8;
  localparam int SW   = 6;

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0, req_upg = 0;
  logic [1:0] req_src = 0;
  logic [SW-1:0] req_set = 0;
  logic [ENT-1:0] mq_valid = 0, mq_upg = 0;
  logic [ENT*SW-1:0] mq_set = 0;
  logic accept, refuse, replay, hit;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  upg_admit_gate #(.NUM_WAYS(WAYS), .MQ_ENTRIES(ENT), .SET_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_upg_i(req_upg),
    .req_src_i(req_src), .req_set_i(req_set), .mq_valid_i(mq_valid),
    .mq_upg_i(mq_upg), .mq_set_i(mq_set), .accept_o(accept), .refuse_o(refuse),
    .replay_o(replay), .hit_o(hit));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // entries 0..k-1 pending upgrades to tgt, plus distractors
  task automatic fill(input int k, input logic [SW-1:0] tgt);
    mq_valid = '0; mq_upg = '0; mq_set = '0;
    for (int e = 0; e < k; e++) begin
      mq_valid[e] = 1; mq_upg[e] = 1; mq_set[e*SW +: SW] = tgt;
    end
    mq_valid[5] = 1; mq_upg[5] = 0; mq_set[5*SW +: SW] = tgt;      // not upgrade
    mq_valid[6] = 1; mq_upg[6] = 1; mq_set[6*SW +: SW] = tgt ^ 6'h1; // other set
    mq_valid[7] = 0; mq_upg[7] = 1; mq_set[7*SW +: SW] = tgt;      // invalid
  endtask

  task automatic issue(input int k, input int src, input logic upg, input logic [SW-1:0] tgt);
    logic capped, exp_ref, exp_acc;
    req_valid = 1; req_upg = upg; req_src = 2'(src); req_set = tgt;
    fill(k, tgt);
    @(negedge clk);
    capped  = (src != 2) && (k >= WAYS - 1);
    exp_ref = upg && capped;
    exp_acc = upg && !capped;
    chk(src == 0 ? "R4 accept(load)" : (src == 2 ? "R5 accept(missq)" : "R2 accept"), accept, exp_acc);
    chk(upg ? "R3 refuse" : "R9 refuse", refuse, exp_ref);
    chk("R6 replay", replay, exp_ref && src == 1);
    chk("R7 hit", hit, !upg && src == 1);
    chk("R7 replay/hit excl", replay && hit, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    req_valid = 1; req_upg = 1; req_src = 1;
    repeat (3) @(negedge clk);
    chk("R1 accept", accept, 0); chk("R1 refuse", refuse, 0);
    chk("R1 replay", replay, 0); chk("R1 hit", hit, 0);
    req_valid = 0;
    rst_ni = 1;
    @(negedge clk);
    chk("R1 post-release", accept | refuse | replay | hit, 0);
    for (int t = 0; t < 3; t++)
      for (int k = 0; k <= 4; k++)
        for (int s = 0; s < 4; s++)
          for (int u = 0; u < 2; u++)
            issue(k, s, u[0], 6'(t * 21 + 2));
    fill(4, 6'd9);
    req_valid = 0; req_upg = 1; req_src = 1; req_set = 6'd9;
    @(negedge clk);
    chk("R8 idle", accept | refuse | replay | hit, 0);
    issue(3, 1, 1, 6'd9);
    req_valid = 0;
    @(negedge clk);
    chk("R8 single-cycle strobe", refuse | replay, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule